// File: doc/BRIEF.md
# DMA Unit Transfer Sequencer

This block carries out a granted DMA run one unit at a time. A unit is a halfword or a word. For each unit the block reads from the working source address and then writes to the working destination address. Both accesses go through a request/acknowledge memory port. After the write the block steps both addresses, counts the unit off and stays busy for the unit's charged cycle cost before it starts the next unit.

The cost of a unit comes from a wait-state table outside the block. The table is looked up by the 4-bit address region, which is address bits 27:24. The block presents the source and destination regions together with a sequential/nonsequential flag and the unit width. The table returns one cost for each region.

When the count reaches zero, the block raises a one-cycle done pulse for the arbiter and the register file. The pulse carries:
- the channel number;
- the decision whether the channel stays enabled;
- the final working source address;
- the destination address to use for a repeat run;
- an optional per-channel interrupt.

Top module: `dmaUnitSeq`

## Requirements
- R1: A pulse on `start` while idle begins a run of `startCount` units, where `startCount` is at least 1. Each unit issues a read request at the source address (`memWe`=0), then a write request at the destination address (`memWe`=1). A request stays asserted with a stable address until `memAck`.
- R2: After the cycle in which a unit's write is acknowledged, the block stays idle on the memory port for exactly the unit cost. It then raises the next unit's first request or `done`. The unit cost is 2 plus the source-region cost plus the destination-region cost. The first unit of a run looks up with `wsSeq`=0 and every later unit with `wsSeq`=1. `wsWide` gives the unit width.
- R3: When `startWide`=0, the 16-bit read data (`memRdata[15:0]`) is copied into both halves of the transfer latch. Every write drives the latch on `memWdata`.
- R4: When the working source address is zero, no read request is made and the current latch value is written. The source address is not stepped, so `doneSrc` is 0.
- R5: The address step per unit depends on the control code. Code 0 adds the width, code 1 subtracts it, code 2 leaves the address unchanged and code 3 adds it. The width is 2 for a halfword and 4 for a word.
- R6: At the end of a run, `doneDst` is the programmed destination when the destination code is 3. Otherwise it is the stepped working destination.
- R7: The last unit of a run costs 2 more cycles when the source region or the destination region is below 8.
- R8: `doneKeep` is 1 only when `startRepeat` is 1 and `startMode` is not 0. Mode 0 is immediate.
- R9: For channel 3 in mode 3, `doneKeep` is 0 when `vLine` equals 161 at `done`.
- R10: During `done`, `irq` has the bit of the run's channel set exactly when `startIrqEn` was 1. `irq` is zero at all other times.
- R11: After reset, `busy`, `memReq`, `done` and `irq` are all 0, and the transfer latch is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (sampled while idle) |
| startCh | input | 2 | Granted channel number |
| startSrc | input | 28 | Programmed source address |
| startDst | input | 28 | Programmed destination address |
| startCount | input | 17 | Units in the run (nonzero) |
| startWide | input | 1 | 1 = 32-bit units, 0 = 16-bit units |
| startSrcCtl | input | 2 | Source step code |
| startDstCtl | input | 2 | Destination step code |
| startRepeat | input | 1 | Repeat enable |
| startMode | input | 2 | Start timing mode, 0 = immediate, 3 = special |
| startIrqEn | input | 1 | Interrupt enable for end of run |
| vLine | input | 9 | Current vertical line counter |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 28 | Access address |
| memWide | output | 1 | Access width, 1 = 32 bits |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Access acknowledge |
| memRdata | input | 32 | Read data, valid with memAck |
| wsSrcRegion | output | 4 | Source region for wait-state lookup |
| wsDstRegion | output | 4 | Destination region for wait-state lookup |
| wsSeq | output | 1 | 1 = sequential access costs |
| wsWide | output | 1 | Unit width for the lookup |
| wsSrcCost | input | 4 | Source access cost |
| wsDstCost | input | 4 | Destination access cost |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| doneCh | output | 2 | Channel of the finished run |
| doneKeep | output | 1 | Channel stays enabled |
| doneSrc | output | 28 | Final working source address |
| doneDst | output | 28 | Destination for the next run |
| irq | output | 4 | Per-channel interrupt pulse |

## Verification
The first request of a run is due the cycle after `start` is taken. A write request follows the cycle after its read is acknowledged. After an acknowledged write, the next unit's first request or `done` is due exactly the unit cost plus one cycle later. The monitor timestamps every acknowledged write and checks that distance against the cost its own model charged. The memory responder and the monitor act on the falling edge, so each comparison sees settled outputs.

// File: rtl/dmaSeqPkg.sv
package dmaSeqPkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_WAIT,
    ST_FINISH
  } seqState_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic load;     // take the start fields
    logic capture;  // read acknowledged: fill the latch
    logic advance;  // write acknowledged: step and count
    logic finish;   // end of run report
  } seqStrobe_t;
endpackage

// File: rtl/dmaSeqCtrl.sv
module dmaSeqCtrl
  import dmaSeqPkg::*;
#(
  parameter int BUSY_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              srcZero,
  input  logic              runEnd,
  input  logic [BUSY_W-1:0] unitCost,
  input  logic              memAck,
  output seqStrobe_t        stb,
  output logic              memReq,
  output logic              memWe,
  output logic              rdPhase,
  output logic              busy
);
  seqState_t         state, nextState;
  logic [BUSY_W-1:0] busyCnt;

  always_comb begin
    stb       = '0;
    nextState = state;
    memReq    = 1'b0;
    memWe     = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        stb.load  = 1'b1;
        nextState = srcZero ? ST_WRITE : ST_READ;
      end
      ST_READ: begin
        memReq = 1'b1;
        if (memAck) begin
          stb.capture = 1'b1;
          nextState   = ST_WRITE;
        end
      end
      ST_WRITE: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          stb.advance = 1'b1;
          nextState   = ST_WAIT;
        end
      end
      ST_WAIT: if (busyCnt == BUSY_W'(1)) begin
        if (runEnd) nextState = ST_FINISH;
        else        nextState = srcZero ? ST_WRITE : ST_READ;
      end
      ST_FINISH: begin
        stb.finish = 1'b1;
        nextState  = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      busyCnt <= '0;
    end else begin
      state <= nextState;
      if (stb.advance)            busyCnt <= unitCost;
      else if (state == ST_WAIT)  busyCnt <= busyCnt - BUSY_W'(1);
    end
  end

  assign rdPhase = (state == ST_READ);
  assign busy    = (state != ST_IDLE);
endmodule

// File: rtl/dmaSeqPath.sv
module dmaSeqPath
  import dmaSeqPkg::*;
#(
  parameter int ADDR_W      = 28,
  parameter int CNT_W       = 17,
  parameter int NUM_CH      = 4,
  parameter int COST_W      = 4,
  parameter int VLINE_W     = 9,
  parameter int STOP_LINE   = 161,
  parameter int CART_REGION = 8,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int BUSY_W = COST_W + 2,
  localparam int REG_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         stb,
  input  logic               rdPhase,
  input  logic [CH_W-1:0]    startCh,
  input  logic [ADDR_W-1:0]  startSrc,
  input  logic [ADDR_W-1:0]  startDst,
  input  logic [CNT_W-1:0]   startCount,
  input  logic               startWide,
  input  logic [1:0]         startSrcCtl,
  input  logic [1:0]         startDstCtl,
  input  logic               startRepeat,
  input  logic [1:0]         startMode,
  input  logic               startIrqEn,
  input  logic [VLINE_W-1:0] vLine,
  input  logic [31:0]        memRdata,
  input  logic [COST_W-1:0]  wsSrcCost,
  input  logic [COST_W-1:0]  wsDstCost,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [31:0]        memWdata,
  output logic               memWide,
  output logic [REG_W-1:0]   wsSrcRegion,
  output logic [REG_W-1:0]   wsDstRegion,
  output logic               wsSeq,
  output logic               srcZero,
  output logic               runEnd,
  output logic [BUSY_W-1:0]  unitCost,
  output logic [CH_W-1:0]    doneCh,
  output logic               doneKeep,
  output logic [ADDR_W-1:0]  doneSrc,
  output logic [ADDR_W-1:0]  doneDst,
  output logic [NUM_CH-1:0]  irq
);
  logic [CH_W-1:0]   chReg;
  logic [ADDR_W-1:0] srcReg, dstReg, dstHome;
  logic [CNT_W-1:0]  cntReg;
  logic              wideReg, firstReg, repeatReg, irqEnReg;
  logic [1:0]        srcCtlReg, dstCtlReg, modeReg;
  logic [31:0]       xferLatch;
  logic              lastUnit, lowRegion, stopLine;

  function automatic logic [ADDR_W-1:0] stepAddr(input logic [ADDR_W-1:0] a,
                                                 input logic [1:0] code,
                                                 input logic wide);
    logic [ADDR_W-1:0] w;
    w = wide ? ADDR_W'(4) : ADDR_W'(2);
    case (code)
      2'd1:    stepAddr = a - w;
      2'd2:    stepAddr = a;
      default: stepAddr = a + w;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chReg     <= '0;
      srcReg    <= '0;
      dstReg    <= '0;
      dstHome   <= '0;
      cntReg    <= '0;
      wideReg   <= 1'b0;
      firstReg  <= 1'b0;
      repeatReg <= 1'b0;
      irqEnReg  <= 1'b0;
      srcCtlReg <= '0;
      dstCtlReg <= '0;
      modeReg   <= '0;
      xferLatch <= '0;
    end else begin
      if (stb.load) begin
        chReg     <= startCh;
        srcReg    <= startSrc;
        dstReg    <= startDst;
        dstHome   <= startDst;
        cntReg    <= startCount;
        wideReg   <= startWide;
        firstReg  <= 1'b1;
        repeatReg <= startRepeat;
        irqEnReg  <= startIrqEn;
        srcCtlReg <= startSrcCtl;
        dstCtlReg <= startDstCtl;
        modeReg   <= startMode;
      end
      if (stb.capture)
        xferLatch <= wideReg ? memRdata : {memRdata[15:0], memRdata[15:0]};
      if (stb.advance) begin
        if (srcReg != '0) srcReg <= stepAddr(srcReg, srcCtlReg, wideReg);
        dstReg   <= stepAddr(dstReg, dstCtlReg, wideReg);
        cntReg   <= cntReg - CNT_W'(1);
        firstReg <= 1'b0;
      end
    end
  end

  // region lookup and cost
  assign wsSrcRegion = srcReg[ADDR_W-1 -: REG_W];
  assign wsDstRegion = dstReg[ADDR_W-1 -: REG_W];
  assign wsSeq       = ~firstReg;
  assign lastUnit    = (cntReg == CNT_W'(1));
  assign lowRegion   = (wsSrcRegion < REG_W'(CART_REGION)) || (wsDstRegion < REG_W'(CART_REGION));
  assign unitCost    = BUSY_W'(2) + BUSY_W'(wsSrcCost) + BUSY_W'(wsDstCost)
                     + ((lastUnit && lowRegion) ? BUSY_W'(2) : BUSY_W'(0));

  // memory side
  assign memAddr  = rdPhase ? srcReg : dstReg;
  assign memWdata = xferLatch;
  assign memWide  = wideReg;
  assign srcZero  = stb.load ? (startSrc == '0) : (srcReg == '0);
  assign runEnd   = (cntReg == '0);

  // end-of-run report
  assign stopLine = (chReg == CH_W'(NUM_CH - 1)) && (modeReg == 2'd3)
                  && (vLine == VLINE_W'(STOP_LINE));
  assign doneKeep = repeatReg && (modeReg != 2'd0) && !stopLine;
  assign doneCh   = chReg;
  assign doneSrc  = srcReg;
  assign doneDst  = (dstCtlReg == 2'd3) ? dstHome : dstReg;

  for (genvar g = 0; g < NUM_CH; g++) begin : gIrq
    assign irq[g] = stb.finish && irqEnReg && (chReg == CH_W'(g));
  end
endmodule

// File: rtl/dmaUnitSeq.sv
module dmaUnitSeq
  import dmaSeqPkg::*;
#(
  parameter int ADDR_W  = 28,
  parameter int CNT_W   = 17,
  parameter int NUM_CH  = 4,
  parameter int COST_W  = 4,
  parameter int VLINE_W = 9,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int BUSY_W = COST_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [CH_W-1:0]    startCh,
  input  logic [ADDR_W-1:0]  startSrc,
  input  logic [ADDR_W-1:0]  startDst,
  input  logic [CNT_W-1:0]   startCount,
  input  logic               startWide,
  input  logic [1:0]         startSrcCtl,
  input  logic [1:0]         startDstCtl,
  input  logic               startRepeat,
  input  logic [1:0]         startMode,
  input  logic               startIrqEn,
  input  logic [VLINE_W-1:0] vLine,
  output logic               memReq,
  output logic               memWe,
  output logic [ADDR_W-1:0]  memAddr,
  output logic               memWide,
  output logic [31:0]        memWdata,
  input  logic               memAck,
  input  logic [31:0]        memRdata,
  output logic [3:0]         wsSrcRegion,
  output logic [3:0]         wsDstRegion,
  output logic               wsSeq,
  output logic               wsWide,
  input  logic [COST_W-1:0]  wsSrcCost,
  input  logic [COST_W-1:0]  wsDstCost,
  output logic               busy,
  output logic               done,
  output logic [CH_W-1:0]    doneCh,
  output logic               doneKeep,
  output logic [ADDR_W-1:0]  doneSrc,
  output logic [ADDR_W-1:0]  doneDst,
  output logic [NUM_CH-1:0]  irq
);
  seqStrobe_t        stb;
  logic              srcZero, runEnd, rdPhase;
  logic [BUSY_W-1:0] unitCost;

  dmaSeqCtrl #(.BUSY_W(BUSY_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .srcZero(srcZero), .runEnd(runEnd),
    .unitCost(unitCost), .memAck(memAck), .stb(stb), .memReq(memReq),
    .memWe(memWe), .rdPhase(rdPhase), .busy(busy)
  );

  dmaSeqPath #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_CH(NUM_CH),
    .COST_W(COST_W), .VLINE_W(VLINE_W)
  ) u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .rdPhase(rdPhase),
    .startCh(startCh), .startSrc(startSrc), .startDst(startDst),
    .startCount(startCount), .startWide(startWide), .startSrcCtl(startSrcCtl),
    .startDstCtl(startDstCtl), .startRepeat(startRepeat), .startMode(startMode),
    .startIrqEn(startIrqEn), .vLine(vLine), .memRdata(memRdata),
    .wsSrcCost(wsSrcCost), .wsDstCost(wsDstCost), .memAddr(memAddr),
    .memWdata(memWdata), .memWide(memWide), .wsSrcRegion(wsSrcRegion),
    .wsDstRegion(wsDstRegion), .wsSeq(wsSeq), .srcZero(srcZero),
    .runEnd(runEnd), .unitCost(unitCost), .doneCh(doneCh),
    .doneKeep(doneKeep), .doneSrc(doneSrc), .doneDst(doneDst), .irq(irq)
  );

  assign wsWide = memWide;
  assign done   = stb.finish;
endmodule

// File: rtl/dmaUnitSeqChk.sv
module dmaUnitSeqChk #(
  parameter int ADDR_W = 28,
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [1:0]        startMode,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memWide,
  input logic [31:0]       memWdata,
  input logic              busy,
  input logic              done,
  input logic              doneKeep,
  input logic [NUM_CH-1:0] irq
);
  logic [1:0] capMode;

  always_ff @(posedge clk) begin
    if (!rstN)               capMode <= '0;
    else if (start && !busy) capMode <= startMode;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe)); // R1

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R1

  AST_HALF_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && !memWide |-> memWdata[31:16] == memWdata[15:0]); // R3

  AST_ZERO_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memWe |-> memAddr != '0); // R4

  AST_IMMEDIATE_STOP: assert property (@(posedge clk) disable iff (!rstN)
    done && capMode == 2'd0 |-> !doneKeep); // R8

  AST_IRQ_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    irq != '0 |-> done && $onehot0(irq)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq && !done); // R11
endmodule

bind dmaUnitSeq dmaUnitSeqChk #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .startMode(startMode),
  .memReq(memReq), .memWe(memWe), .memAck(memAck), .memAddr(memAddr),
  .memWide(memWide), .memWdata(memWdata), .busy(busy), .done(done),
  .doneKeep(doneKeep), .irq(irq)
);

// File: tb/test_dmaUnitSeq.sv
module test_dmaUnitSeq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  startCh = '0;
  logic [27:0] startSrc = '0, startDst = '0;
  logic [16:0] startCount = '0;
  logic        startWide = 1'b0;
  logic [1:0]  startSrcCtl = '0, startDstCtl = '0, startMode = '0;
  logic        startRepeat = 1'b0, startIrqEn = 1'b0;
  logic [8:0]  vLine = '0;
  logic        memReq, memWe, memWide, memAck = 1'b0;
  logic [27:0] memAddr;
  logic [31:0] memWdata, memRdata = '0;
  logic [3:0]  wsSrcRegion, wsDstRegion, wsSrcCost, wsDstCost;
  logic        wsSeq, wsWide, busy, done, doneKeep;
  logic [1:0]  doneCh;
  logic [27:0] doneSrc, doneDst;
  logic [3:0]  irq;

  always #10 clk = ~clk;

  dmaUnitSeq i_dmaUnitSeq (.*);

  // bench wait-state table and memory contents
  function automatic logic [3:0] wsFn(input logic [3:0] region, input logic seq, input logic wide);
    return 4'(region % 4) + (seq ? 4'd0 : 4'd3) + (wide ? 4'd1 : 4'd0);
  endfunction
  function automatic logic [31:0] rdFn(input logic [27:0] a);
    return {~a[15:0], a[15:0] + 16'h0101};
  endfunction
  assign wsSrcCost = wsFn(wsSrcRegion, wsSeq, wsWide);
  assign wsDstCost = wsFn(wsDstRegion, wsSeq, wsWide);

  typedef struct {
    int          kind;   // 0 read, 1 write, 2 done
    logic [27:0] addr;
    logic [31:0] data;
    int          cost;
    logic [1:0]  ch;
    logic        keep;
    logic [27:0] fSrc, fDst;
    logic [3:0]  irqV;
  } item_t;
  item_t q[$];

  int vecs = 0, errs = 0;
  int cyc = 0;
  int tw = 0, gapCost = 0;
  bit gapPending = 0;
  logic [31:0] latchM = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [27:0] stepM(input logic [27:0] a, input logic [1:0] c, input logic wide);
    int w = wide ? 4 : 2;
    if (c == 2'd1) return a - 28'(w);
    if (c == 2'd2) return a;
    return a + 28'(w);
  endfunction

  // driver: model the run and push expected items, then start it
  task automatic runOne(input logic [1:0] ch, input logic wide, input logic [27:0] src,
                        input logic [27:0] dst, input int cnt, input logic [1:0] sCtl,
                        input logic [1:0] dCtl, input logic rep, input logic [1:0] mode,
                        input logic irqEn, input logic [8:0] line);
    logic [27:0] s = src, d = dst;
    logic [31:0] rv;
    item_t it;
    for (int i = 0; i < cnt; i++) begin
      it = '{default: '0};
      if (s != '0) begin
        rv = rdFn(s);
        latchM = wide ? rv : {rv[15:0], rv[15:0]};
        it.kind = 0; it.addr = s;
        q.push_back(it);
      end
      it = '{default: '0};
      it.kind = 1; it.addr = d; it.data = latchM;
      it.cost = 2 + int'(wsFn(s[27:24], i != 0, wide)) + int'(wsFn(d[27:24], i != 0, wide))
              + (((i == cnt - 1) && (s[27:24] < 4'd8 || d[27:24] < 4'd8)) ? 2 : 0);
      q.push_back(it);
      if (s != '0) s = stepM(s, sCtl, wide);
      d = stepM(d, dCtl, wide);
    end
    it = '{default: '0};
    it.kind = 2; it.ch = ch;
    it.keep = rep && mode != 2'd0 && !(ch == 2'd3 && mode == 2'd3 && line == 9'd161);
    it.fSrc = s;
    it.fDst = (dCtl == 2'd3) ? dst : d;
    it.irqV = irqEn ? (4'd1 << ch) : 4'd0;
    q.push_back(it);
    @(negedge clk);
    startCh = ch; startWide = wide; startSrc = src; startDst = dst;
    startCount = 17'(cnt); startSrcCtl = sCtl; startDstCtl = dCtl;
    startRepeat = rep; startMode = mode; startIrqEn = irqEn; vLine = line;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (q.size() != 0 || busy) @(negedge clk);
  endtask

  task automatic gapCheck();
    if (gapPending) begin
      check(cyc - tw == gapCost + 1, "R2/R7", "unit cost gap", 32'(cyc - tw), 32'(gapCost + 1));
      gapPending = 0;
    end
  endtask

  // memory responder and scoreboard monitor
  always @(negedge clk) begin
    item_t e;
    if (rstN) begin
      if (memAck) memAck = 1'b0;
      else if (memReq) begin
        if (q.size() == 0) check(0, "R1", "unexpected request", 32'(memAddr), 0);
        else begin
          e = q.pop_front();
          check(e.kind == int'(memWe), "R1/R4", "access kind", 32'(memWe), 32'(e.kind));
          check(memAddr == e.addr, "R1/R5", "access address", 32'(memAddr), 32'(e.addr));
          if (e.kind == 1) begin
            check(memWdata == e.data, "R3/R4", "write data", memWdata, e.data);
            gapCheck();
            gapPending = 1; tw = cyc; gapCost = e.cost;
          end else begin
            gapCheck();
            memRdata = rdFn(memAddr);
          end
        end
        memAck = 1'b1;
      end
      if (done) begin
        if (q.size() == 0) check(0, "R1", "unexpected done", 1, 0);
        else begin
          e = q.pop_front();
          check(e.kind == 2, "R1", "done too early", 32'(2), 32'(e.kind));
          gapCheck();
          check(doneCh == e.ch, "R1", "doneCh", 32'(doneCh), 32'(e.ch));
          check(doneKeep == e.keep, "R8/R9", "doneKeep", 32'(doneKeep), 32'(e.keep));
          check(doneSrc == e.fSrc, "R4/R5", "doneSrc", 32'(doneSrc), 32'(e.fSrc));
          check(doneDst == e.fDst, "R5/R6", "doneDst", 32'(doneDst), 32'(e.fDst));
          check(irq == e.irqV, "R10", "irq", 32'(irq), 32'(e.irqV));
        end
      end else if (irq != '0) check(0, "R10", "irq outside done", 32'(irq), 0);
    end
  end

  bit finished = 0;
  initial begin
    #(20 * 100000);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog expired actual=%0d expected=0", q.size());
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 0, "R11", "busy after reset", 32'(busy), 0);
    check(memReq == 0, "R11", "memReq after reset", 32'(memReq), 0);
    check(done == 0 && irq == 0, "R11", "done/irq after reset", 32'({done, irq}), 0);
    // R1 R2 R5 R7 R8 R10: 32-bit, source down, destination fixed, line mode, repeat kept
    runOne(2'd1, 1'b1, 28'h3000100, 28'h6000010, 2, 2'd1, 2'd2, 1'b1, 2'd1, 1'b0, 9'd0);
    // R3 R8 R10: halfword, immediate mode stops even with repeat
    runOne(2'd0, 1'b0, 28'h2000200, 28'h7000000, 3, 2'd0, 2'd0, 1'b1, 2'd0, 1'b1, 9'd0);
    // R4 R6: zero source reuses mirrored latch, destination reload code 3
    runOne(2'd2, 1'b0, 28'h0000000, 28'h5000040, 2, 2'd0, 2'd3, 1'b0, 2'd2, 1'b1, 9'd0);
    // R9: channel 3 special mode at the stop line, high regions (no extra cost)
    runOne(2'd3, 1'b1, 28'h8000000, 28'h9000000, 1, 2'd3, 2'd0, 1'b1, 2'd3, 1'b1, 9'd161);
    // R9 R5: channel 3 special mode elsewhere keeps, source code 3 steps up
    runOne(2'd3, 1'b1, 28'h8000020, 28'h3000000, 3, 2'd3, 2'd0, 1'b1, 2'd3, 1'b0, 9'd100);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule